// File: doc/BRIEF.md
# Fractional Complex Multiplier with Operand Conjugation

This block multiplies two complex numbers held in Q15 two's complement fractional form. Each operand, X and Y, has a 16-bit real part and a 16-bit imaginary part. Each operand sits in its own input register, and each register has its own load enable. Either operand can be conjugated on the way in. One result leaves the block on every clock, whatever conjugation is selected. The four partial products are kept at full Q30 precision. Any partial product whose two factors are both -1 is clamped to the largest positive value. The real and imaginary sums carry one guard bit, so each sum is 33 bits wide.

A two-bit window select picks the 16-bit slice of each wide sum that reaches the outputs:

| Select | Slice of the 33-bit sum | Overflow handling |
|--------|-------------------------|-------------------|
| 00 | bits [31:16] | none |
| 01 | bits [30:15] | saturates |
| 10 | bits [15:0] | none |
| 11 | bits [31:16], same as 00 | none |

A rounding control adds half an output LSB before the slice is taken. The real and imaginary outputs each have an output enable. When its enable is low, an output goes to high impedance. All data and control inputs are captured on the rising clock edge.

Top module: `cplx_frac_mul`

## Requirements
- R1: Reset is synchronous and active high. It clears the operand, control, product, result and output-enable registers. Both outputs are high impedance after any edge that samples reset high, and an all-zero result follows reset.
- R2: The X operand register loads only on an edge where `x_en_i` is high, and the Y operand register loads only on an edge where `y_en_i` is high. When its enable is low, a register keeps its value while the rest of the pipeline keeps advancing.
- R3: Operands and controls captured at edge k show up on the outputs after edge k+2. For example, X = Y = 0x4000 + j0 in window 00 gives 0x1000 on the real output two edges after capture, and 0 one edge after capture.
- R4: The real sum is XR·YR − XI·YI and the imaginary sum is XR·YI + XI·YR, each 33 bits wide. `x_conj_i` high replaces XI with −XI, and `y_conj_i` high replaces YI with −YI. Any combination is allowed at full rate.
- R5: A partial product whose two stored factors both equal 0x8000 becomes 0x3FFFFFFF instead of 0x40000000. When conjugation applies to that product, it negates the trapped value.
- R6: Window select 00 and 11 drive bits [31:16] of the (rounded) sum, without saturation.
- R7: Window select 01 drives bits [30:15] of the (rounded) sum. Values above 0x7FFF are clamped to 0x7FFF, and values below −0x8000 are clamped to 0x8000.
- R8: Window select 10 drives bits [15:0] of the sum. The rounding control has no effect in this window.
- R9: When `rnd_i` is high, 2^15 (window 00/11) or 2^14 (window 01) is added to the sum before the slice is taken. In window 01, saturation is applied after this addition.
- R10: `re_oe_i` and `im_oe_i` are sampled at each edge and act independently. A low sample puts that output at high impedance after the edge. A high sample drives the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_re_i | input | 16 | X real part, Q15 |
| x_im_i | input | 16 | X imaginary part, Q15 |
| y_re_i | input | 16 | Y real part, Q15 |
| y_im_i | input | 16 | Y imaginary part, Q15 |
| x_en_i | input | 1 | Load enable of the X operand register |
| y_en_i | input | 1 | Load enable of the Y operand register |
| x_conj_i | input | 1 | Conjugate X (negate its imaginary part) |
| y_conj_i | input | 1 | Conjugate Y (negate its imaginary part) |
| rnd_i | input | 1 | Round to the selected output window |
| win_sel_i | input | 2 | Output window select (00/11, 01, 10) |
| re_oe_i | input | 1 | Output enable of the real result |
| im_oe_i | input | 1 | Output enable of the imaginary result |
| p_re_o | output | 16 | Real result, high impedance when disabled |
| p_im_o | output | 16 | Imaginary result, high impedance when disabled |

## Verification
Operand and control values captured at one edge reach the outputs after the second edge that follows. Output enables take effect after the very edge that samples them. The bench has a model that mirrors the registers defined by the requirements, including held operands under low enables. It keeps a two-deep history of expected results and compares each sample against the entry from two edges earlier, gated by the enable sampled at the latest edge. Samples are taken at the falling edge. The latency requirement also gets an explicit impulse test, which checks that the result is still zero one edge after capture and correct one edge later.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Output window selection; the code values are the win_sel_i encodings.
    typedef enum logic [1:0] {
        WIN_HIGH = 2'b00,
        WIN_SAT  = 2'b01,
        WIN_LOW  = 2'b10,
        WIN_RSVD = 2'b11
    } win_sel_e;

    // Control word that travels down the pipeline beside the data.
    typedef struct packed {
        logic     conj_x;
        logic     conj_y;
        logic     rnd;
        win_sel_e win;
    } ctl_t;

    // The reserved code behaves like the high window.
    function automatic win_sel_e win_norm(input logic [1:0] raw);
        return (raw == 2'b11) ? WIN_HIGH : win_sel_e'(raw);
    endfunction

endpackage

// File: rtl/cmul_opnd_reg.sv
module cmul_opnd_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] re_i,
    input  logic [DW-1:0] im_i,
    output logic [DW-1:0] re_q,
    output logic [DW-1:0] im_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            re_q <= '0;
            im_q <= '0;
        end else if (en) begin
            re_q <= re_i;
            im_q <= im_i;
        end
    end

endmodule

// File: rtl/cmul_prod_stage.sv
module cmul_prod_stage
    import cmul_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DW-1:0]      xr_i,
    input  logic [DW-1:0]      xi_i,
    input  logic [DW-1:0]      yr_i,
    input  logic [DW-1:0]      yi_i,
    input  ctl_t               ctl_i,
    output ctl_t               ctl_o,
    output logic [3:0][PW-1:0] pp_o
);

    localparam logic [DW-1:0] NEG_ONE = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] POS_MAX = {2'b00, {(PW-2){1'b1}}};

    // Lane order: 0 = xr*yr, 1 = xi*yi, 2 = xr*yi, 3 = xi*yr.
    logic [3:0][DW-1:0] fa;
    logic [3:0][DW-1:0] fb;
    logic [3:0]         flip;
    logic [3:0][PW-1:0] pp_d;

    always_comb begin
        fa[0] = xr_i;  fb[0] = yr_i;
        fa[1] = xi_i;  fb[1] = yi_i;
        fa[2] = xr_i;  fb[2] = yi_i;
        fa[3] = xi_i;  fb[3] = yr_i;
        // Conjugation becomes a sign on the finished product, so no
        // operand is ever negated (-1 in Q15 has no positive twin).
        flip[0] = 1'b0;
        flip[1] = ~(ctl_i.conj_x ^ ctl_i.conj_y);
        flip[2] = ctl_i.conj_y;
        flip[3] = ctl_i.conj_x;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic signed [PW-1:0] raw;
        logic        [PW-1:0] trapped;
        logic                 both_min;

        assign raw      = $signed(fa[g]) * $signed(fb[g]);
        assign both_min = (fa[g] == NEG_ONE) && (fb[g] == NEG_ONE);
        assign trapped  = both_min ? POS_MAX : raw;
        assign pp_d[g]  = flip[g] ? (~trapped + 1'b1) : trapped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_o  <= '0;
            ctl_o <= '0;
        end else begin
            pp_o  <= pp_d;
            ctl_o <= ctl_i;
        end
    end

endmodule

// File: rtl/cmul_out_stage.sv
module cmul_out_stage
    import cmul_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = 2 * DW,
    localparam int SW = PW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0][PW-1:0] pp_i,
    input  ctl_t               ctl_i,
    input  logic               oe_re_i,
    input  logic               oe_im_i,
    output logic [DW-1:0]      re_o,
    output logic [DW-1:0]      im_o,
    output logic               oe_re_o,
    output logic               oe_im_o
);

    localparam logic signed [SW:0] HALF_HI  = {{(SW+1-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
    localparam logic signed [SW:0] HALF_SAT = {{(SW+2-DW){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [SW:0] SAT_MAX  = {{(SW+2-DW){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW:0] SAT_MIN  = {{(SW+2-DW){1'b1}}, {(DW-1){1'b0}}};

    logic [1:0][DW-1:0] res_d;

    // Lane 0 sums products 0 and 1 (real), lane 1 sums 2 and 3 (imag).
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic        [PW-1:0] a;
        logic        [PW-1:0] b;
        logic signed [SW-1:0] sum;
        logic signed [SW:0]   half;
        logic signed [SW:0]   biased;
        logic signed [SW:0]   shifted;
        logic        [DW-1:0] pick;

        assign a   = pp_i[2*g];
        assign b   = pp_i[2*g+1];
        assign sum = $signed({a[PW-1], a}) + $signed({b[PW-1], b});

        always_comb begin
            case (ctl_i.win)
                WIN_SAT: half = ctl_i.rnd ? HALF_SAT : '0;
                WIN_LOW: half = '0;
                default: half = ctl_i.rnd ? HALF_HI : '0;
            endcase
            biased  = $signed({sum[SW-1], sum}) + half;
            shifted = biased >>> (DW - 1);
            case (ctl_i.win)
                WIN_SAT: begin
                    if (shifted > SAT_MAX)      pick = SAT_MAX[DW-1:0];
                    else if (shifted < SAT_MIN) pick = SAT_MIN[DW-1:0];
                    else                        pick = shifted[DW-1:0];
                end
                WIN_LOW: pick = sum[DW-1:0];
                default: pick = biased[PW-1:DW];
            endcase
        end

        assign res_d[g] = pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            re_o    <= '0;
            im_o    <= '0;
            oe_re_o <= 1'b0;
            oe_im_o <= 1'b0;
        end else begin
            re_o    <= res_d[0];
            im_o    <= res_d[1];
            oe_re_o <= oe_re_i;
            oe_im_o <= oe_im_i;
        end
    end

endmodule

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul
    import cmul_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] x_re_i,
    input  logic [DW-1:0] x_im_i,
    input  logic [DW-1:0] y_re_i,
    input  logic [DW-1:0] y_im_i,
    input  logic          x_en_i,
    input  logic          y_en_i,
    input  logic          x_conj_i,
    input  logic          y_conj_i,
    input  logic          rnd_i,
    input  logic [1:0]    win_sel_i,
    input  logic          re_oe_i,
    input  logic          im_oe_i,
    output logic [DW-1:0] p_re_o,
    output logic [DW-1:0] p_im_o
);

    localparam int PW = 2 * DW;

    logic [DW-1:0]      x_re_q, x_im_q, y_re_q, y_im_q;
    ctl_t               ctl_q;
    ctl_t               ctl_m;
    logic [3:0][PW-1:0] pp_q;
    logic [DW-1:0]      re_q, im_q;
    logic               oe_re_q, oe_im_q;

    // Stage 1: operand registers with their own enables, control register.
    cmul_opnd_reg #(.DW(DW)) x_reg_i (
        .clk (clk), .rst (rst), .en (x_en_i),
        .re_i(x_re_i), .im_i(x_im_i),
        .re_q(x_re_q), .im_q(x_im_q)
    );

    cmul_opnd_reg #(.DW(DW)) y_reg_i (
        .clk (clk), .rst (rst), .en (y_en_i),
        .re_i(y_re_i), .im_i(y_im_i),
        .re_q(y_re_q), .im_q(y_im_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q.conj_x <= x_conj_i;
            ctl_q.conj_y <= y_conj_i;
            ctl_q.rnd    <= rnd_i;
            ctl_q.win    <= win_norm(win_sel_i);
        end
    end

    // Stage 2: trapped, signed partial products.
    cmul_prod_stage #(.DW(DW)) prod_i (
        .clk  (clk),    .rst (rst),
        .xr_i (x_re_q), .xi_i(x_im_q),
        .yr_i (y_re_q), .yi_i(y_im_q),
        .ctl_i(ctl_q),  .ctl_o(ctl_m),
        .pp_o (pp_q)
    );

    // Stage 3: sums, rounding, window, saturation, output registers.
    cmul_out_stage #(.DW(DW)) out_i (
        .clk    (clk),     .rst    (rst),
        .pp_i   (pp_q),    .ctl_i  (ctl_m),
        .oe_re_i(re_oe_i), .oe_im_i(im_oe_i),
        .re_o   (re_q),    .im_o   (im_q),
        .oe_re_o(oe_re_q), .oe_im_o(oe_im_q)
    );

    assign p_re_o = oe_re_q ? re_q : 'z;
    assign p_im_o = oe_im_q ? im_q : 'z;

endmodule

// File: rtl/cmul_chk.sv
module cmul_chk #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input logic               clk,
    input logic               rst,
    input logic               x_en_i,
    input logic               y_en_i,
    input logic [DW-1:0]      x_re_q,
    input logic [DW-1:0]      x_im_q,
    input logic [DW-1:0]      y_re_q,
    input logic [DW-1:0]      y_im_q,
    input logic [3:0][PW-1:0] pp_q
);

    localparam logic [DW-1:0] NEG_ONE = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] POS_MAX = {2'b00, {(PW-2){1'b1}}};

    AST_HOLD_X: assert property (@(posedge clk) disable iff (rst)
        !x_en_i |=> ($stable(x_re_q) && $stable(x_im_q)));             // R2

    AST_HOLD_Y: assert property (@(posedge clk) disable iff (rst)
        !y_en_i |=> ($stable(y_re_q) && $stable(y_im_q)));             // R2

    AST_TRAP_REAL: assert property (@(posedge clk) disable iff (rst)
        (x_re_q == NEG_ONE && y_re_q == NEG_ONE) |=> (pp_q[0] == POS_MAX)); // R5

    AST_ZERO_X_ZERO_PROD: assert property (@(posedge clk) disable iff (rst)
        (x_re_q == '0 && x_im_q == '0) |=> (pp_q == '0));              // R4

endmodule

bind cplx_frac_mul cmul_chk #(.DW(DW)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .x_en_i(x_en_i),
    .y_en_i(y_en_i),
    .x_re_q(x_re_q),
    .x_im_q(x_im_q),
    .y_re_q(y_re_q),
    .y_im_q(y_im_q),
    .pp_q  (pp_q)
);

// File: tb/cplx_frac_mul_tb.sv
module cplx_frac_mul_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic [15:0] x_re, x_im, y_re, y_im;
    logic        x_en, y_en, x_conj, y_conj, rnd;
    logic [1:0]  win_sel;
    logic        re_oe, im_oe;
    logic [15:0] p_re, p_im;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string phase = "R1";

    // Model of the registers the requirements define.
    logic signed [15:0] mxr, mxi, myr, myi;
    logic               mcx, mcy, mrnd, moe_r, moe_i;
    logic [1:0]         msel;
    logic [31:0]        h0, h1, h2;

    cplx_frac_mul dut_i (
        .clk(clk), .rst(rst),
        .x_re_i(x_re), .x_im_i(x_im), .y_re_i(y_re), .y_im_i(y_im),
        .x_en_i(x_en), .y_en_i(y_en), .x_conj_i(x_conj), .y_conj_i(y_conj),
        .rnd_i(rnd), .win_sel_i(win_sel), .re_oe_i(re_oe), .im_oe_i(im_oe),
        .p_re_o(p_re), .p_im_o(p_im)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic longint tprod(longint a, longint b);
        if (a == -32768 && b == -32768) return 64'sd1073741823;
        return a * b;
    endfunction

    function automatic logic [15:0] window(longint s, logic r, logic [1:0] sel);
        longint v;
        case (sel)
            2'b01: begin
                v = (s + (r ? 64'sd16384 : 64'sd0)) >>> 15;
                if (v > 32767)  v = 32767;
                if (v < -32768) v = -32768;
            end
            2'b10:   v = s;
            default: v = (s + (r ? 64'sd32768 : 64'sd0)) >>> 16;
        endcase
        return v[15:0];
    endfunction

    function automatic logic [31:0] expect_of();
        longint rr, ii, ri, ir, sr, si;
        rr = tprod(longint'(mxr), longint'(myr));
        ii = tprod(longint'(mxi), longint'(myi));
        ri = tprod(longint'(mxr), longint'(myi));
        ir = tprod(longint'(mxi), longint'(myr));
        sr = (mcx ^ mcy) ? rr + ii : rr - ii;
        si = (mcy ? -ri : ri) + (mcx ? -ir : ir);
        return {window(sr, mrnd, msel), window(si, mrnd, msel)};
    endfunction

    task automatic cmp(string tag, logic [15:0] got, logic [15:0] exp, logic en);
        logic [15:0] want;
        want  = en ? exp : 16'hzzzz;
        n_cmp = n_cmp + 1;
        if (got !== want) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            mxr = 0; mxi = 0; myr = 0; myi = 0;
            mcx = 0; mcy = 0; mrnd = 0; msel = 0; moe_r = 0; moe_i = 0;
            h1 = 0; h2 = 0;
        end else begin
            if (x_en) begin mxr = x_re; mxi = x_im; end
            if (y_en) begin myr = y_re; myi = y_im; end
            mcx = x_conj; mcy = y_conj; mrnd = rnd; msel = win_sel;
            moe_r = re_oe; moe_i = im_oe;
        end
        @(negedge clk);
        h2 = h1;
        h1 = h0;
        h0 = expect_of();
        if (rst) begin
            cmp({phase, " reset real"}, p_re, 16'h0, 1'b0);
            cmp({phase, " reset imag"}, p_im, 16'h0, 1'b0);
        end else begin
            cmp({phase, " real"}, p_re, h2[31:16], moe_r);
            cmp({phase, " imag"}, p_im, h2[15:0],  moe_i);
        end
    endtask

    task automatic drive(logic [15:0] xr, logic [15:0] xi, logic [15:0] yr, logic [15:0] yi,
                         logic cx, logic cy, logic r, logic [1:0] sel);
        x_re = xr; x_im = xi; y_re = yr; y_im = yi;
        x_conj = cx; y_conj = cy; rnd = r; win_sel = sel;
    endtask

    function automatic logic [15:0] rv();
        case ($urandom % 5)
            0:       return 16'h8000;
            1:       return 16'h7FFF;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic rand_cycle(bit vary_en, bit vary_oe);
        drive(rv(), rv(), rv(), rv(), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        x_en  = vary_en ? 1'($urandom) : 1'b1;
        y_en  = vary_en ? 1'($urandom) : 1'b1;
        re_oe = vary_oe ? 1'($urandom) : 1'b1;
        im_oe = vary_oe ? 1'($urandom) : 1'b1;
        tick();
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        x_en = 1'b1; y_en = 1'b1; re_oe = 1'b1; im_oe = 1'b1;
        drive(16'h1234, 16'h5678, 16'h1111, 16'h2222, 1'b0, 1'b0, 1'b0, 2'b00);
        h0 = 0; h1 = 0; h2 = 0;
        // R1: outputs high impedance while reset is sampled, zeros after.
        phase = "R1";
        repeat (3) tick();
        rst = 1'b0;
        drive(16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        repeat (3) tick();

        // R3: impulse latency, checked explicitly.
        phase = "R3";
        drive(16'h4000, 16'h0, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        tick();
        drive(16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        tick();
        cmp("R3 one edge after capture", p_re, 16'h0000, 1'b1);
        tick();
        cmp("R3 two edges after capture", p_re, 16'h1000, 1'b1);
        repeat (2) tick();

        // R4: every conjugation combination.
        phase = "R4 conj";
        for (int c = 0; c < 4; c++) begin
            drive(16'h2000, 16'h1000, 16'h3000, 16'h0800, c[0], c[1], 1'b0, 2'b01);
            tick();
            drive(16'hE000, 16'h7FFF, 16'h8000, 16'hC000, c[0], c[1], 1'b1, 2'b00);
            tick();
        end

        // R5: trapped -1 x -1 products, with and without conjugation.
        phase = "R5 trap";
        drive(16'h8000, 16'h0, 16'h8000, 16'h0, 1'b0, 1'b0, 1'b0, 2'b01);
        tick();
        drive(16'h0, 16'h8000, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 2'b01);
        tick();
        drive(16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, 2'b10);
        tick();
        drive(16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b1, 1'b1, 2'b00);
        tick();

        // R6: high window and the reserved code.
        phase = "R6 high window";
        drive(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 2'b00);
        tick();
        drive(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 2'b11);
        tick();

        // R7: saturation in both directions.
        phase = "R7 saturate";
        drive(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 2'b01);
        tick();
        drive(16'h8000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1, 2'b01);
        tick();

        // R8: low window, rounding must not matter.
        phase = "R8 low window";
        drive(16'h1235, 16'h4321, 16'h0F0F, 16'h8001, 1'b0, 1'b1, 1'b1, 2'b10);
        tick();
        drive(16'h1235, 16'h4321, 16'h0F0F, 16'h8001, 1'b0, 1'b1, 1'b0, 2'b10);
        tick();

        // R9: rounding near the half LSB in the two rounding windows.
        phase = "R9 round";
        drive(16'h0001, 16'h0, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b1, 2'b01);
        tick();
        drive(16'h0002, 16'h0, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b1, 2'b00);
        tick();
        drive(16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b1, 2'b01);
        tick();
        repeat (300) begin
            drive(rv(), rv(), rv(), rv(), 1'($urandom), 1'($urandom), 1'b1, 2'($urandom));
            tick();
        end

        // R2: gated operand registers.
        phase = "R2 enables";
        repeat (600) rand_cycle(1'b1, 1'b0);

        // R10: independent output enables.
        phase = "R10 output enable";
        repeat (400) rand_cycle(1'b0, 1'b1);

        phase = "R4 random";
        repeat (2500) rand_cycle(1'b1, 1'b1);
        repeat (3) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule